// File: doc/BRIEF.md
# Context-Switched Eight-Lane Formatter Pipeline

This block is a five-stage pipeline of processing elements that reshapes and combines two 128-bit operand vectors, each split into eight 16-bit lanes. Every stage has eight lane ALUs and a lane permutation network. It also has a private table of four configurations. A 2-bit context ID travels down the pipeline with the operands and a valid flag. On every cycle each stage applies the configuration that the arriving ID selects, so neighbouring stages can run different contexts in the same cycle.

An issue controller feeds stage 0. It walks through a fixed sequence of entries written beforehand as control code. Each entry names a context ID and the set of input buffers that context needs. The controller has two states. In **IDLE** it waits, and the named transition *start* moves it to **RUN** at entry 0. In **RUN** it issues the current entry in any cycle where every required buffer flag is set, one entry per cycle. The transition *advance* stays in RUN and moves to the next entry. The transition *finish* is taken when the issued entry carries its last flag, and it returns to IDLE. While the flags are missing it waits in RUN and issues nothing.

Top module: `fmt_pipe_top`

## Requirements
- R1: An entry issued in cycle t appears at `out_vld` with its context ID on `out_id` after exactly five clock edges, one register per stage.
- R2: Each lane ALU obeys its own 3-bit opcode. 0 adds A+B, 1 subtracts A-B, 2 passes A, 3 passes B, 4 shifts A left by one bit, and 5 to 7 give zero. All results wrap modulo 2^16.
- R3: Each lane drives two results. With its route bit at 0, both the A and the B outputs carry the ALU result. With the route bit at 1, the B output carries the lane's incoming B value unchanged.
- R4: After the ALUs, both vectors pass through the same permutation, chosen by a 2-bit pattern. Output lane i takes lane p(i), with p(i)=i for pattern 0, i XOR 1 for pattern 1, i XOR 2 for pattern 2 and 7-i for pattern 3. Lane k occupies bits 16k+15..16k.
- R5: A stage applies the configuration addressed by the ID that arrives with valid data in that cycle. Back-to-back entries with different IDs are each processed under their own context in every stage.
- R6: A stage that receives valid=0 keeps its data and ID outputs unchanged and presents valid=0 on the next cycle.
- R7: In RUN, the controller issues only in a cycle where every buffer flag in the entry's mask is set on `buf_vld`. It can issue on consecutive cycles.
- R8: Entries are issued in sequence order from address 0. The entry with the last flag set returns the controller to IDLE. `start` is ignored while in RUN, and `busy` is high exactly in RUN.
- R9: A configuration write stores a 34-bit word for one (stage, context) pair. Lane k's opcode is in bits 4k+2..4k and its route bit in bit 4k+3. The pattern is in bits 33..32. The word is used by data that arrives in the cycles after the write edge. A sequence entry holds the ID in bits 1..0, the buffer mask in bits 5..2 and the last flag in bit 6.
- R10: After reset, `out_vld`, `out_id`, `out_a`, `out_b`, `busy` and `iss_vld` are all zero. Every configuration word reads as zero, which means add, route 0 and pattern 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stage | input | 3 | Stage addressed by the write |
| cfg_ctx | input | 2 | Context addressed by the write |
| cfg_word | input | 34 | Configuration word |
| seq_we | input | 1 | Sequence entry write strobe |
| seq_addr | input | 4 | Sequence entry address |
| seq_entry | input | 7 | Sequence entry: ID, mask, last |
| start | input | 1 | Begin the sequence from entry 0 |
| buf_vld | input | 4 | Input buffer valid flags |
| opa_in | input | 128 | Operand vector A |
| opb_in | input | 128 | Operand vector B |
| busy | output | 1 | Controller is in RUN |
| iss_vld | output | 1 | An entry is issued this cycle |
| iss_id | output | 2 | Context ID of the current entry |
| out_vld | output | 1 | Final stage result valid |
| out_id | output | 2 | Context ID of the final result |
| out_a | output | 128 | Final A vector |
| out_b | output | 128 | Final B vector |

## Verification
On every cycle the assertions check four things. Valid and ID must step one stage per edge. Stage outputs must stay frozen behind a valid=0 input. An issue can happen only in RUN. Entry into RUN must follow a start pulse. The lane arithmetic, the route bits, the permutations, the choice of context per stage, the gating by buffer flags, the sequence order and the effect of a fresh configuration write show up only in the bench scenarios. There, a behavioural model of the requirements predicts every output on every cycle, and directed runs compare known end-to-end results.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    localparam int LANES = 8;
    localparam int LW    = 16;
    localparam int NSTG  = 5;
    localparam int NCTX  = 4;
    localparam int NBUF  = 4;
    localparam int SEQD  = 16;
    localparam int OPW   = 3;
    localparam int SPW   = 2;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_PA  = 3'd2,
        OP_PB  = 3'd3,
        OP_SHL = 3'd4
    } alu_op_e;

    typedef enum logic [0:0] {
        IS_IDLE = 1'b0,
        IS_RUN  = 1'b1
    } iss_state_e;
endpackage

// File: rtl/fmt_cfg_mem.sv
module fmt_cfg_mem #(
    parameter int CW   = 34,
    parameter int NCTX = 4,
    localparam int AW  = $clog2(NCTX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [CW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [CW-1:0] rdata
);
    logic [CW-1:0] mem [NCTX];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCTX; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fmt_stage.sv
module fmt_stage
    import fmt_pkg::*;
#(
    parameter int LANES = fmt_pkg::LANES,
    parameter int LW    = fmt_pkg::LW,
    parameter int NCTX  = fmt_pkg::NCTX,
    localparam int IDW  = $clog2(NCTX),
    localparam int DW   = LANES * LW,
    localparam int LCW  = OPW + 1,
    localparam int CW   = LANES * LCW + SPW,
    localparam int LIW  = $clog2(LANES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [IDW-1:0] cfg_ctx,
    input  logic [CW-1:0]  cfg_word,
    input  logic           in_vld,
    input  logic [IDW-1:0] in_id,
    input  logic [DW-1:0]  in_a,
    input  logic [DW-1:0]  in_b,
    output logic           out_vld,
    output logic [IDW-1:0] out_id,
    output logic [DW-1:0]  out_a,
    output logic [DW-1:0]  out_b
);
    logic [CW-1:0]  cw;
    logic [LW-1:0]  res  [LANES];
    logic [LW-1:0]  resb [LANES];
    logic [DW-1:0]  sh_a, sh_b;
    logic [SPW-1:0] pat;

    fmt_cfg_mem #(.CW(CW), .NCTX(NCTX)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_ctx),
        .wdata(cfg_word), .raddr(in_id), .rdata(cw)
    );

    function automatic logic [LIW-1:0] perm(input logic [SPW-1:0] p, input logic [LIW-1:0] i);
        case (p)
            2'd0:    perm = i;
            2'd1:    perm = i ^ LIW'(1);
            2'd2:    perm = i ^ LIW'(2);
            default: perm = LIW'(LANES - 1) - i;
        endcase
    endfunction

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [OPW-1:0] op;
            logic           route;
            logic [LW-1:0]  x, y;
            assign op    = cw[l*LCW +: OPW];
            assign route = cw[l*LCW + OPW];
            assign x     = in_a[l*LW +: LW];
            assign y     = in_b[l*LW +: LW];
            always_comb begin
                case (op)
                    OP_ADD:  res[l] = x + y;
                    OP_SUB:  res[l] = x - y;
                    OP_PA:   res[l] = x;
                    OP_PB:   res[l] = y;
                    OP_SHL:  res[l] = x << 1;
                    default: res[l] = '0;
                endcase
                resb[l] = route ? y : res[l];
            end
        end
    endgenerate

    assign pat = cw[LANES*LCW +: SPW];

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            sh_a[i*LW +: LW] = res[perm(pat, LIW'(i))];
            sh_b[i*LW +: LW] = resb[perm(pat, LIW'(i))];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_id  <= '0;
            out_a   <= '0;
            out_b   <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_id <= in_id;
                out_a  <= sh_a;
                out_b  <= sh_b;
            end
        end
    end
endmodule

// File: rtl/fmt_issue.sv
module fmt_issue
    import fmt_pkg::*;
#(
    parameter int NCTX  = fmt_pkg::NCTX,
    parameter int NBUF  = fmt_pkg::NBUF,
    parameter int SEQD  = fmt_pkg::SEQD,
    localparam int IDW  = $clog2(NCTX),
    localparam int SAW  = $clog2(SEQD),
    localparam int SEW  = IDW + NBUF + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           seq_we,
    input  logic [SAW-1:0] seq_addr,
    input  logic [SEW-1:0] seq_entry,
    input  logic [NBUF-1:0] buf_vld,
    output logic           busy,
    output logic           iss_vld,
    output logic [IDW-1:0] iss_id
);
    iss_state_e     state, nstate;
    logic [SAW-1:0] ptr, nptr;
    logic [SEW-1:0] seq_mem [SEQD];
    logic [SEW-1:0] cur;
    logic           ready, last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEQD; i++) seq_mem[i] <= '0;
        end else if (seq_we) begin
            seq_mem[seq_addr] <= seq_entry;
        end
    end

    assign cur   = seq_mem[ptr];
    assign ready = (cur[IDW +: NBUF] & ~buf_vld) == '0;
    assign last  = cur[SEW-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= IS_IDLE;
            ptr   <= '0;
        end else begin
            state <= nstate;
            ptr   <= nptr;
        end
    end

    always_comb begin
        nstate = state;
        nptr   = ptr;
        unique case (state)
            IS_IDLE: if (start) begin
                nstate = IS_RUN;
                nptr   = '0;
            end
            IS_RUN: if (ready) begin
                if (last) nstate = IS_IDLE;
                else      nptr   = ptr + SAW'(1);
            end
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        iss_vld = 1'b0;
        iss_id  = cur[IDW-1:0];
        unique case (state)
            IS_IDLE: ;
            IS_RUN: begin
                busy    = 1'b1;
                iss_vld = ready;
            end
        endcase
    end
endmodule

// File: rtl/fmt_pipe_top.sv
module fmt_pipe_top
    import fmt_pkg::*;
#(
    parameter int LANES = fmt_pkg::LANES,
    parameter int LW    = fmt_pkg::LW,
    parameter int NSTG  = fmt_pkg::NSTG,
    parameter int NCTX  = fmt_pkg::NCTX,
    parameter int NBUF  = fmt_pkg::NBUF,
    parameter int SEQD  = fmt_pkg::SEQD,
    localparam int IDW  = $clog2(NCTX),
    localparam int DW   = LANES * LW,
    localparam int CW   = LANES * (OPW + 1) + SPW,
    localparam int STW  = $clog2(NSTG),
    localparam int SAW  = $clog2(SEQD),
    localparam int SEW  = IDW + NBUF + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [STW-1:0]  cfg_stage,
    input  logic [IDW-1:0]  cfg_ctx,
    input  logic [CW-1:0]   cfg_word,
    input  logic            seq_we,
    input  logic [SAW-1:0]  seq_addr,
    input  logic [SEW-1:0]  seq_entry,
    input  logic            start,
    input  logic [NBUF-1:0] buf_vld,
    input  logic [DW-1:0]   opa_in,
    input  logic [DW-1:0]   opb_in,
    output logic            busy,
    output logic            iss_vld,
    output logic [IDW-1:0]  iss_id,
    output logic            out_vld,
    output logic [IDW-1:0]  out_id,
    output logic [DW-1:0]   out_a,
    output logic [DW-1:0]   out_b
);
    logic [NSTG:0]           vld_s;
    logic [NSTG:0][IDW-1:0]  id_s;
    logic [NSTG:0][DW-1:0]   a_s;
    logic [NSTG:0][DW-1:0]   b_s;

    fmt_issue #(.NCTX(NCTX), .NBUF(NBUF), .SEQD(SEQD)) u_iss (
        .clk(clk), .rst_n(rst_n), .start(start), .seq_we(seq_we),
        .seq_addr(seq_addr), .seq_entry(seq_entry), .buf_vld(buf_vld),
        .busy(busy), .iss_vld(iss_vld), .iss_id(iss_id)
    );

    assign vld_s[0] = iss_vld;
    assign id_s[0]  = iss_id;
    assign a_s[0]   = opa_in;
    assign b_s[0]   = opb_in;

    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_stg
            fmt_stage #(.LANES(LANES), .LW(LW), .NCTX(NCTX)) u_stg (
                .clk(clk), .rst_n(rst_n),
                .cfg_we(cfg_we && (cfg_stage == STW'(s))),
                .cfg_ctx(cfg_ctx), .cfg_word(cfg_word),
                .in_vld(vld_s[s]), .in_id(id_s[s]), .in_a(a_s[s]), .in_b(b_s[s]),
                .out_vld(vld_s[s+1]), .out_id(id_s[s+1]),
                .out_a(a_s[s+1]), .out_b(b_s[s+1])
            );
        end
    endgenerate

    assign out_vld = vld_s[NSTG];
    assign out_id  = id_s[NSTG];
    assign out_a   = a_s[NSTG];
    assign out_b   = b_s[NSTG];
endmodule

// File: rtl/fmt_pipe_chk.sv
module fmt_pipe_chk #(
    parameter int NSTG = 5,
    parameter int IDW  = 2,
    parameter int DW   = 128
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    iss_vld,
    input logic [NSTG:0]           vld_s,
    input logic [NSTG:0][IDW-1:0]  id_s,
    input logic [NSTG:0][DW-1:0]   a_s,
    input logic [NSTG:0][DW-1:0]   b_s
);
    generate
        for (genvar k = 0; k < NSTG; k++) begin : g_chk
            AST_VLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                vld_s[k+1] == $past(vld_s[k])); // R1
            AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                vld_s[k] |=> id_s[k+1] == $past(id_s[k])); // R5
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !vld_s[k] |=> $stable(a_s[k+1]) && $stable(b_s[k+1]) && $stable(id_s[k+1])); // R6
        end
    endgenerate

    AST_ISSUE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> busy); // R7
    AST_RUN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R8
endmodule

bind fmt_pipe_top fmt_pipe_chk #(.NSTG(NSTG), .IDW(IDW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .iss_vld(iss_vld),
    .vld_s(vld_s), .id_s(id_s), .a_s(a_s), .b_s(b_s)
);

// File: tb/sim_fmt_pipe_top.sv
`timescale 1ns/1ps
module sim_fmt_pipe_top;
    localparam int LANES = 8, LW = 16, NSTG = 5, NCTX = 4, NBUF = 4, SEQD = 16;
    localparam int DW = LANES * LW, CW = LANES * 4 + 2, SEW = 2 + NBUF + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0, seq_we = 0, start = 0;
    logic [2:0] cfg_stage = 0;
    logic [1:0] cfg_ctx = 0;
    logic [CW-1:0] cfg_word = 0;
    logic [3:0] seq_addr = 0;
    logic [SEW-1:0] seq_entry = 0;
    logic [NBUF-1:0] buf_vld = 0;
    logic [DW-1:0] opa_in = 0, opb_in = 0;
    logic busy, iss_vld, out_vld;
    logic [1:0] iss_id, out_id;
    logic [DW-1:0] out_a, out_b;

    int total = 0, bad = 0;
    bit fin = 0;
    string tag = "R10";

    always #2.5 clk = ~clk;

    fmt_pipe_top u0 (.*);

    // behavioural reference state
    logic [CW-1:0]  mcfg [NSTG][NCTX];
    logic [SEW-1:0] mseq [SEQD];
    bit             mrun;
    int             mptr;
    bit             mv  [NSTG];
    logic [1:0]     mid [NSTG];
    logic [DW-1:0]  ma  [NSTG];
    logic [DW-1:0]  mb  [NSTG];

    function automatic int pidx(int p, int i);
        if (p == 0) return i;
        if (p == 1) return i ^ 1;
        if (p == 2) return i ^ 2;
        return LANES - 1 - i;
    endfunction

    function automatic logic [2*DW-1:0] stage_f(logic [CW-1:0] w, logic [DW-1:0] a, logic [DW-1:0] b);
        logic [LW-1:0] r [LANES];
        logic [LW-1:0] q [LANES];
        logic [DW-1:0] oa, ob;
        for (int l = 0; l < LANES; l++) begin
            logic [LW-1:0] x, y;
            x = a[l*LW +: LW];
            y = b[l*LW +: LW];
            case (int'(w[l*4 +: 3]))
                0: r[l] = x + y;
                1: r[l] = x - y;
                2: r[l] = x;
                3: r[l] = y;
                4: r[l] = {x[LW-2:0], 1'b0};
                default: r[l] = '0;
            endcase
            q[l] = w[l*4+3] ? y : r[l];
        end
        for (int i = 0; i < LANES; i++) begin
            oa[i*LW +: LW] = r[pidx(int'(w[33:32]), i)];
            ob[i*LW +: LW] = q[pidx(int'(w[33:32]), i)];
        end
        return {oa, ob};
    endfunction

    function automatic bit m_ready();
        return mrun && ((mseq[mptr][2 +: NBUF] & ~buf_vld) == '0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSTG; s++) begin
                mv[s] = 0; mid[s] = 0; ma[s] = 0; mb[s] = 0;
                for (int c = 0; c < NCTX; c++) mcfg[s][c] = '0;
            end
            for (int e = 0; e < SEQD; e++) mseq[e] = '0;
            mrun = 0; mptr = 0;
        end else begin
            bit iss;
            iss = m_ready();
            for (int s = NSTG - 1; s >= 0; s--) begin
                bit vi; logic [1:0] ii; logic [DW-1:0] ai, bi;
                if (s == 0) begin vi = iss; ii = mseq[mptr][1:0]; ai = opa_in; bi = opb_in; end
                else begin vi = mv[s-1]; ii = mid[s-1]; ai = ma[s-1]; bi = mb[s-1]; end
                mv[s] = vi;
                if (vi) begin
                    mid[s] = ii;
                    {ma[s], mb[s]} = stage_f(mcfg[s][ii], ai, bi);
                end
            end
            if (!mrun) begin
                if (start) begin mrun = 1; mptr = 0; end
            end else if (iss) begin
                if (mseq[mptr][SEW-1]) mrun = 0;
                else mptr = (mptr + 1) % SEQD;
            end
            if (cfg_we && cfg_stage < NSTG) mcfg[cfg_stage][cfg_ctx] = cfg_word;
            if (seq_we) mseq[seq_addr] = seq_entry;
        end
    end

    task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(out_vld == mv[NSTG-1] && (!out_vld || out_id == mid[NSTG-1]), "R1", "vld/id",
                DW'({out_vld, out_id}), DW'({mv[NSTG-1], mid[NSTG-1]}));
            chk(out_a == ma[NSTG-1] && out_b == mb[NSTG-1], tag, "out_a/out_b",
                out_a ^ out_b, ma[NSTG-1] ^ mb[NSTG-1]);
            chk(iss_vld == m_ready() && (!iss_vld || iss_id == mseq[mptr][1:0]), "R7", "issue",
                DW'({iss_vld, iss_id}), DW'({m_ready(), mseq[mptr][1:0]}));
            chk(busy == mrun, "R8", "busy", DW'(busy), DW'(mrun));
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin
            @(negedge clk); #1;
            cfg_we = 0; seq_we = 0; start = 0;
            opa_in = {$urandom, $urandom, $urandom, $urandom};
            opb_in = {$urandom, $urandom, $urandom, $urandom};
        end
    endtask

    task automatic wr_cfg(int s, int c, logic [CW-1:0] w);
        @(negedge clk); #1;
        cfg_we = 1; cfg_stage = 3'(s); cfg_ctx = 2'(c); cfg_word = w;
        seq_we = 0; start = 0;
    endtask

    task automatic wr_seq(int a, logic [1:0] id, logic [3:0] mask, bit last);
        @(negedge clk); #1;
        seq_we = 1; seq_addr = 4'(a); seq_entry = {last, mask, id};
        cfg_we = 0; start = 0;
    endtask

    task automatic do_start();
        @(negedge clk); #1;
        start = 1; cfg_we = 0; seq_we = 0;
    endtask

    function automatic logic [CW-1:0] mk_cw(int s, int c);
        logic [CW-1:0] w;
        for (int l = 0; l < LANES; l++) begin
            w[l*4 +: 3] = 3'((s * 3 + c + l) % 8);
            w[l*4 + 3]  = 1'((s + c + l) % 2);
        end
        w[33:32] = 2'((s + c) % 4);
        return w;
    endfunction

    function automatic logic [DW-1:0] swap_adj(logic [DW-1:0] v);
        logic [DW-1:0] o;
        for (int i = 0; i < LANES; i++) o[i*LW +: LW] = v[(i ^ 1)*LW +: LW];
        return o;
    endfunction

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            total++; bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] fa, fb, ea;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(out_vld == 0 && out_id == 0 && busy == 0 && iss_vld == 0, "R10", "ctl after reset",
            DW'({out_vld, out_id, busy, iss_vld}), '0);
        chk(out_a == 0 && out_b == 0, "R10", "data after reset", out_a | out_b, '0);
        #1 rst_n = 1;
        step(2);

        // R9: load all contexts
        tag = "R9";
        for (int s = 0; s < NSTG; s++)
            for (int c = 0; c < NCTX; c++) wr_cfg(s, c, mk_cw(s, c));
        // R5 / R2 / R4: back-to-back mixed contexts
        tag = "R5";
        wr_seq(0, 0, 0, 0); wr_seq(1, 1, 0, 0); wr_seq(2, 2, 0, 0);
        wr_seq(3, 3, 0, 0); wr_seq(4, 2, 0, 0); wr_seq(5, 1, 0, 1);
        buf_vld = 4'hF;
        do_start();
        step(14);
        // R8: start while running is ignored, sequence restarts only from IDLE
        tag = "R8";
        do_start();
        step(2);
        do_start();
        step(14);

        // R7 / R6: gated issue with bubbles
        tag = "R6";
        buf_vld = 0;
        wr_seq(0, 1, 4'b0100, 0); wr_seq(1, 3, 4'b1010, 0); wr_seq(2, 0, 4'b0001, 1);
        do_start();
        step(6);
        buf_vld = 4'b0100; step(3);
        buf_vld = 4'b0010; step(3);
        buf_vld = 4'b1010; step(2);
        buf_vld = 4'b0001; step(12);

        // R3 / R4: pass A, route B through, adjacent swap in every stage
        tag = "R3";
        buf_vld = 4'hF;
        for (int s = 0; s < NSTG; s++) wr_cfg(s, 2, {2'd1, {LANES{4'b1010}}});
        wr_seq(0, 2, 0, 1);
        do_start();
        @(negedge clk); #1;
        fa = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
        fb = 128'hA0A0_B1B1_C2C2_D3D3_E4E4_F5F5_0606_1717;
        opa_in = fa; opb_in = fb;
        @(negedge clk);
        while (!out_vld) @(negedge clk);
        chk(out_a == swap_adj(fa), "R4", "odd swap of A", out_a, swap_adj(fa));
        chk(out_b == swap_adj(fb), "R3", "B routed through", out_b, swap_adj(fb));
        step(3);

        // R2 / R3: shift in every stage, both outputs equal
        tag = "R2";
        for (int s = 0; s < NSTG; s++) wr_cfg(s, 3, {2'd0, {LANES{4'b0100}}});
        wr_seq(0, 3, 0, 1);
        do_start();
        @(negedge clk); #1;
        fa = 128'h0001_0003_0800_FFFF_0010_8000_0402_0101;
        opa_in = fa; opb_in = '0;
        for (int i = 0; i < LANES; i++) ea[i*LW +: LW] = fa[i*LW +: LW] << 5;
        @(negedge clk);
        while (!out_vld) @(negedge clk);
        chk(out_a == ea, "R2", "five shifts", out_a, ea);
        chk(out_b == ea, "R3", "default dual output", out_b, ea);
        step(3);

        // R1: latency of five edges from the issue cycle
        @(negedge clk);
        while (busy) @(negedge clk);
        do_start();
        @(negedge clk);
        chk(iss_vld == 1, "R1", "issue seen", DW'(iss_vld), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_vld == 0, "R1", "early output", DW'(out_vld), 0);
        end
        @(negedge clk);
        chk(out_vld == 1 && out_id == 3, "R1", "output at fifth edge",
            DW'({out_vld, out_id}), DW'({1'b1, 2'd3}));
        step(4);

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule